// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block caches recent virtual-to-physical page translations for one requester. Every slot can hold any translation. A lookup presents a virtual page number, and the block compares it against all slots in the same cycle. A slot matches only when its page number and its address-space tag both equal the request's page number and the current context identifier. Because every slot is tagged, a context switch only changes `cur_asid`. The cache does not have to be emptied. The block still offers a global flush and a flush of a single address space.

The lookup result is registered, so it appears one cycle after the request. On a hit the block returns the frame number and protection bits. It also reports the slot's referenced and modified flags as they stood before this access. A hit marks the slot referenced. A write hit marks it modified when the page is writable, and raises a protection fault when it is not. On a miss, the requester walks its page tables and installs the result through the fill port. The fill port picks its target slot in this order: a slot already holding the same page and tag, then the lowest free slot, then the least recently used slot.

Top module: `tlb_assoc`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. The response reflects the cache contents before any update made in the request cycle.
- R2: A response is a hit only if some valid slot holds both `lk_vpn` and `cur_asid`. A hit returns that slot's frame number and protection. A miss drives `rsp_pfn`, `rsp_prot`, `rsp_fault`, `rsp_ref` and `rsp_mod` to zero.
- R3: `rsp_ref` and `rsp_mod` give the slot's referenced and modified flags before the access. Any lookup hit leaves the slot's referenced flag set.
- R4: Protection bit 0 means writable. A write hit on a writable slot sets its modified flag. A write hit on a slot with bit 0 clear raises `rsp_fault` and leaves the modified flag unchanged.
- R5: A fill installs a valid slot with the given page number, tag, frame number and protection. The referenced and modified flags are cleared, and a later matching lookup hits it.
- R6: A fill whose page number and tag match a valid slot overwrites that slot. Otherwise the fill takes the lowest-numbered invalid slot, and only when no slot is free does it take the LRU slot.
- R7: The LRU slot is the one whose last fill or lookup hit lies furthest in the past.
- R8: `flush_all` invalidates every slot. A fill presented in the same cycle as any flush is dropped.
- R9: `flush_asid_valid` invalidates exactly the valid slots whose tag equals `flush_asid`. Slots with other tags keep hitting.
- R10: At most one slot matches any lookup.
- R11: After reset every slot is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a store |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| cur_asid | input | ASID_W | Current address-space identifier |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Address-space tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_prot | input | PROT_W | Protection bits, bit 0 = writable |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_valid | input | 1 | Invalidate the slots of one address space |
| flush_asid | input | ASID_W | Address space to invalidate |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation found |
| rsp_pfn | output | PFN_W | Translated frame number |
| rsp_prot | output | PROT_W | Protection bits of the hit slot |
| rsp_fault | output | 1 | Write hit on a non-writable page |
| rsp_ref | output | 1 | Referenced flag before this access |
| rsp_mod | output | 1 | Modified flag before this access |

## Verification
The bench refills a page and tag that are already cached. A design that allocated a second slot here would later return two slots' frame numbers ORed together. It stores to read-only pages, where a design that set the modified flag anyway would show it on the next read. It flushes one address space while another holds the same page numbers, which catches a flush that ignores the tag. It fills after a partial flush, where a design that skipped the free-slot preference would evict the oldest live translation. It also runs a flush and a fill in the same cycle and evicts from a full cache after selective touches. A wrong recency order then shows up as the wrong page going missing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where a fill lands, in order of preference.
    typedef enum logic [1:0] {
        SRC_MATCH = 2'd0,
        SRC_FREE  = 2'd1,
        SRC_LRU   = 2'd2
    } fill_src_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 28
) (
    input  logic [ENTRIES-1:0]            slot_valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0] slot_key,
    input  logic [KEY_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec
);

    // One comparator per slot, all working at once.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = slot_valid[g] && (slot_key[g] == key);
    end

endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    // Each slot holds a distinct age rank; 0 is newest, ENTRIES-1 is oldest.
    logic [ENTRIES-1:0][IDX_W-1:0] age_d, age_q;
    logic [ENTRIES-1:0]            oldest_vec;
    logic                          oldest_found;
    logic [IDX_W-1:0]              oldest_idx;

    always_comb begin
        age_d = age_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            oldest_vec[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
        end
    end

    tlb_first #(.ENTRIES(ENTRIES)) u_oldest (
        .vec   (oldest_vec),
        .found (oldest_found),
        .idx   (oldest_idx)
    );

    assign victim_idx = oldest_found ? oldest_idx : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PROT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              flush_all,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PROT_W-1:0] rsp_prot,
    output logic              rsp_fault,
    output logic              rsp_ref,
    output logic              rsp_mod
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int KEY_W = ASID_W + VPN_W;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PROT_W-1:0] prot;
        logic              refd;
        logic              mod;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic                rsp_valid;
        logic                rsp_hit;
        logic [PFN_W-1:0]    rsp_pfn;
        logic [PROT_W-1:0]   rsp_prot;
        logic                rsp_fault;
        logic                rsp_ref;
        logic                rsp_mod;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][KEY_W-1:0] key_vec;
    logic [ENTRIES-1:0]            lk_hit_vec, fill_hit_vec;
    logic                          lk_hit, fill_hit, free_found;
    logic [IDX_W-1:0]              lk_idx, fill_idx, free_idx, victim_idx;
    logic [IDX_W-1:0]              fill_tgt;
    logic                          fill_go, touch;
    logic [IDX_W-1:0]              touch_idx;
    fill_src_e                     fill_src;
    slot_t                         hit_slot;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_vec[i] = s_q.slot[i].valid;
            key_vec[i]   = {s_q.slot[i].asid, s_q.slot[i].vpn};
        end
    end

    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
        .slot_valid (valid_vec),
        .slot_key   (key_vec),
        .key        ({cur_asid, lk_vpn}),
        .hit_vec    (lk_hit_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_fill_match (
        .slot_valid (valid_vec),
        .slot_key   (key_vec),
        .key        ({fill_asid, fill_vpn}),
        .hit_vec    (fill_hit_vec)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_lk_enc (
        .vec (lk_hit_vec), .found (lk_hit), .idx (lk_idx)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_fill_enc (
        .vec (fill_hit_vec), .found (fill_hit), .idx (fill_idx)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_free_enc (
        .vec (~valid_vec), .found (free_found), .idx (free_idx)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    always_comb begin
        s_d      = s_q;
        hit_slot = s_q.slot[lk_idx];

        // Fill target: existing copy, then free slot, then oldest.
        if (fill_hit)        fill_src = SRC_MATCH;
        else if (free_found) fill_src = SRC_FREE;
        else                 fill_src = SRC_LRU;
        case (fill_src)
            SRC_MATCH: fill_tgt = fill_idx;
            SRC_FREE:  fill_tgt = free_idx;
            default:   fill_tgt = victim_idx;
        endcase
        fill_go = fill_valid && !flush_all && !flush_asid_valid;

        // Registered response, taken from the state before this cycle.
        s_d.rsp_valid = lk_valid;
        s_d.rsp_hit   = lk_valid && lk_hit;
        s_d.rsp_pfn   = '0;
        s_d.rsp_prot  = '0;
        s_d.rsp_fault = 1'b0;
        s_d.rsp_ref   = 1'b0;
        s_d.rsp_mod   = 1'b0;
        if (lk_valid && lk_hit) begin
            s_d.rsp_pfn   = hit_slot.pfn;
            s_d.rsp_prot  = hit_slot.prot;
            s_d.rsp_fault = lk_write && !hit_slot.prot[0];
            s_d.rsp_ref   = hit_slot.refd;
            s_d.rsp_mod   = hit_slot.mod;
            s_d.slot[lk_idx].refd = 1'b1;
            if (lk_write && hit_slot.prot[0]) begin
                s_d.slot[lk_idx].mod = 1'b1;
            end
        end

        if (fill_go) begin
            s_d.slot[fill_tgt] = '{valid: 1'b1, asid: fill_asid, vpn: fill_vpn,
                                   pfn: fill_pfn, prot: fill_prot,
                                   refd: 1'b0, mod: 1'b0};
        end

        for (int i = 0; i < ENTRIES; i++) begin
            if (flush_all || (flush_asid_valid && s_q.slot[i].asid == flush_asid)) begin
                s_d.slot[i].valid = 1'b0;
            end
        end

        // A fill's recency update takes precedence over a lookup's.
        touch     = fill_go || (lk_valid && lk_hit);
        touch_idx = fill_go ? fill_tgt : lk_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_pfn   = s_q.rsp_pfn;
    assign rsp_prot  = s_q.rsp_prot;
    assign rsp_fault = s_q.rsp_fault;
    assign rsp_ref   = s_q.rsp_ref;
    assign rsp_mod   = s_q.rsp_mod;

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_write,
    input logic               flush_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PFN_W-1:0]   rsp_pfn,
    input logic               rsp_fault,
    input logic               rsp_ref,
    input logic               rsp_mod,
    input logic [ENTRIES-1:0] lk_hit_vec,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R1

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R1

    AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && !rsp_fault && !rsp_ref && !rsp_mod)); // R2

    AST_FAULT_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && $past(lk_write))); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0)); // R8

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R10

endmodule

bind tlb_assoc tlb_assoc_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .flush_all  (flush_all),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_pfn    (rsp_pfn),
    .rsp_fault  (rsp_fault),
    .rsp_ref    (rsp_ref),
    .rsp_mod    (rsp_mod),
    .lk_hit_vec (lk_hit_vec),
    .valid_vec  (valid_vec)
);

// File: tb/sim_tlb_assoc.sv
`timescale 1ns/1ps
module sim_tlb_assoc;

    localparam int N  = 16;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int AW = 8;
    localparam int RW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          lk_valid = 0, lk_write = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] cur_asid = '0;
    logic          fill_valid = 0;
    logic [VW-1:0] fill_vpn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [RW-1:0] fill_prot = '0;
    logic          flush_all = 0, flush_asid_valid = 0;
    logic [AW-1:0] flush_asid = '0;
    logic          rsp_valid, rsp_hit, rsp_fault, rsp_ref, rsp_mod;
    logic [PW-1:0] rsp_pfn;
    logic [RW-1:0] rsp_prot;

    tlb_assoc #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .PROT_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vpn(lk_vpn), .cur_asid(cur_asid), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .fill_prot(fill_prot), .flush_all(flush_all),
        .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .rsp_prot(rsp_prot), .rsp_fault(rsp_fault), .rsp_ref(rsp_ref),
        .rsp_mod(rsp_mod)
    );

    int checks = 0;
    int errors = 0;
    int now = 0;
    bit done = 0;

    // Reference model of the slots.
    logic          m_val [N];
    logic [AW-1:0] m_asid[N];
    logic [VW-1:0] m_vpn [N];
    logic [PW-1:0] m_pfn [N];
    logic [RW-1:0] m_prot[N];
    logic          m_ref [N];
    logic          m_mod [N];
    int            m_used[N];

    task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int find(logic [VW-1:0] vpn, logic [AW-1:0] asid);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int pick_target(logic [VW-1:0] vpn, logic [AW-1:0] asid);
        int t;
        t = find(vpn, asid);
        if (t >= 0) return t;
        for (int i = 0; i < N; i++) if (!m_val[i]) return i;
        t = 0;
        for (int i = 1; i < N; i++) if (m_used[i] < m_used[t]) t = i;
        return t;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_pfn[i] = '0;
            m_prot[i] = '0; m_ref[i] = 0; m_mod[i] = 0; m_used[i] = -i - 1;
        end
    endtask

    task automatic do_fill(logic [VW-1:0] vpn, logic [AW-1:0] asid,
                           logic [PW-1:0] pfn, logic [RW-1:0] prot);
        int t;
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_prot = prot;
        @(negedge clk);
        fill_valid = 0;
        t = pick_target(vpn, asid);
        m_val[t] = 1; m_asid[t] = asid; m_vpn[t] = vpn; m_pfn[t] = pfn;
        m_prot[t] = prot; m_ref[t] = 0; m_mod[t] = 0; m_used[t] = now; now++;
    endtask

    task automatic do_lookup(string req, logic [VW-1:0] vpn, logic wr);
        int t;
        t = find(vpn, cur_asid);
        @(negedge clk);
        lk_valid = 1; lk_vpn = vpn; lk_write = wr;
        @(negedge clk);
        lk_valid = 0; lk_write = 0;
        check("R1", "rsp_valid", rsp_valid, 1);
        check(req, "hit", rsp_hit, (t >= 0));
        check("R2", "pfn", rsp_pfn, (t >= 0) ? m_pfn[t] : '0);
        check("R2", "prot", rsp_prot, (t >= 0) ? m_prot[t] : '0);
        check("R4", "fault", rsp_fault, (t >= 0) && wr && !m_prot[t][0]);
        check("R3", "ref", rsp_ref, (t >= 0) ? m_ref[t] : 1'b0);
        check("R3", "mod", rsp_mod, (t >= 0) ? m_mod[t] : 1'b0);
        if (t >= 0) begin
            m_ref[t] = 1;
            if (wr && m_prot[t][0]) m_mod[t] = 1;
            m_used[t] = now; now++;
        end
    endtask

    task automatic do_flush_all(bit with_fill, logic [VW-1:0] vpn);
        @(negedge clk);
        flush_all = 1;
        fill_valid = with_fill; fill_vpn = vpn; fill_asid = cur_asid;
        fill_pfn = 20'h5a5a5; fill_prot = 3'b001;
        @(negedge clk);
        flush_all = 0; fill_valid = 0;
        for (int i = 0; i < N; i++) m_val[i] = 0;
    endtask

    task automatic do_flush_asid(logic [AW-1:0] a);
        @(negedge clk);
        flush_asid_valid = 1; flush_asid = a;
        @(negedge clk);
        flush_asid_valid = 0;
        for (int i = 0; i < N; i++) if (m_asid[i] == a) m_val[i] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11", "rsp_valid after reset", rsp_valid, 0);
        cur_asid = 8'd1;
        do_lookup("R11", 20'd5, 0);

        // Install and touch; flags reported as before the access.
        do_fill(20'd5, 8'd1, 20'h00123, 3'b001);
        do_lookup("R5", 20'd5, 0);
        check("R3", "ref after one hit", rsp_ref, 0);
        do_lookup("R3", 20'd5, 0);
        check("R3", "ref seen on second hit", rsp_ref, 1);
        do_lookup("R4", 20'd5, 1);
        do_lookup("R4", 20'd5, 0);
        check("R4", "mod after writable store", rsp_mod, 1);

        // Read-only store faults and leaves the page clean.
        do_fill(20'd6, 8'd1, 20'h00456, 3'b010);
        do_lookup("R4", 20'd6, 1);
        check("R4", "fault on read-only store", rsp_fault, 1);
        do_lookup("R4", 20'd6, 0);
        check("R4", "mod stays clear", rsp_mod, 0);

        // Tag mismatch misses.
        cur_asid = 8'd2;
        do_lookup("R2", 20'd5, 0);
        check("R2", "other asid misses", rsp_hit, 0);

        // Refill of a cached key overwrites in place.
        do_fill(20'd5, 8'd1, 20'h00777, 3'b001);
        cur_asid = 8'd1;
        do_lookup("R6", 20'd5, 0);
        check("R6", "refilled pfn", rsp_pfn, 20'h00777);
        check("R6", "refill clears mod", rsp_mod, 0);

        // Selective flush.
        do_fill(20'd5, 8'd2, 20'h00888, 3'b001);
        do_flush_asid(8'd1);
        do_lookup("R9", 20'd5, 0);
        check("R9", "flushed asid misses", rsp_hit, 0);
        cur_asid = 8'd2;
        do_lookup("R9", 20'd5, 0);
        check("R9", "other asid survives", rsp_pfn, 20'h00888);

        // Flush with a colliding fill.
        do_flush_all(1, 20'd9);
        do_lookup("R8", 20'd5, 0);
        do_lookup("R8", 20'd9, 0);
        check("R8", "colliding fill dropped", rsp_hit, 0);

        // LRU eviction after selective touch.
        cur_asid = 8'd0;
        for (int i = 0; i < N; i++) do_fill(VW'(100 + i), 8'd0, PW'(i), 3'b001);
        do_lookup("R7", 20'd100, 0);
        do_fill(20'd200, 8'd0, 20'h0abcd, 3'b001);
        do_lookup("R7", 20'd101, 0);
        check("R7", "oldest page evicted", rsp_hit, 0);
        do_lookup("R7", 20'd100, 0);
        check("R7", "touched page kept", rsp_hit, 1);

        // Free slot beats the LRU slot.
        do_flush_all(0, 20'd0);
        for (int i = 0; i < N; i++) do_fill(VW'(300 + i), AW'(i % 2), PW'(i), 3'b001);
        do_flush_asid(8'd1);
        do_fill(20'd400, 8'd0, 20'h00400, 3'b001);
        do_lookup("R6", 20'd300, 0);
        check("R6", "oldest live page kept", rsp_hit, 1);

        // Constrained random traffic.
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(99);
            if (r < 8) cur_asid = AW'($urandom_range(3));
            r = $urandom_range(99);
            if (r < 60)
                do_lookup("R2", VW'($urandom_range(31)), 1'($urandom_range(1)));
            else if (r < 95)
                do_fill(VW'($urandom_range(31)), AW'($urandom_range(3)),
                        PW'($urandom), RW'($urandom));
            else if (r < 99)
                do_flush_asid(AW'($urandom_range(3)));
            else
                do_flush_all(1'($urandom_range(1)), VW'($urandom_range(31)));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule